// File: doc/BRIEF.md
# Minimum OR-Flip Bit Counter

This engine takes three unsigned operands and works out how few single-bit inversions, applied to the first two operands, make their bitwise OR equal to the third. It is bit-serial and looks at one bit position per clock. Every position above the most significant set bit of the OR of all three operands is zero in each operand, so it needs no flip, and the engine never visits it. The scan therefore starts at that bit and runs down to bit 0. Small operands finish in a few cycles and wide ones take up to one cycle per bit.

A caller presents the operands with a one-cycle `start` while `busy` is low. It then waits for the one-cycle `done` pulse and reads `flipCount`, which stays valid until the next accepted start.

Top module: `orflip_counter`

## Requirements
- R1: While reset is active and in the first cycle after it, `busy` and `done` are 0 and `flipCount` is 0.
- R2: At a visited position where the bit of `opC` is 0, the count grows by the sum of the bits of `opA` and `opB` at that position (0, 1 or 2).
- R3: At a visited position where the bit of `opC` is 1, the count grows by 1 only if the bits of `opA` and `opB` there are both 0. Otherwise it does not grow.
- R4: If `opA|opB|opC` is nonzero with highest set bit m, `done` is seen after exactly m+1 rising edges following the edge that accepts `start`. Positions m down to 0 are each visited once.
- R5: If `opA|opB|opC` is zero, `done` is high in the cycle right after the accepting edge, and `flipCount` is 0.
- R6: A `start` that arrives while `busy` is high is ignored, and the result of the running scan is unchanged.
- R7: `done` is high for exactly one cycle. `flipCount` holds its value until the next accepted `start`.
- R8: `flipCount` is $clog2(2*WIDTH+1) bits wide and can reach 2*WIDTH. Operands all-ones, all-ones, zero give 64 at WIDTH=32.
- R9: `busy` is high from the cycle after the accepting edge through the `done` cycle, and low afterwards.
- R10: Operands (1, 2, 3) give 0, operands (51041, 65280, 716177407) give 14, and operands (143165576, 715827882, 1) give 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept operands when not busy |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opC | input | WIDTH | Target of the OR |
| busy | output | 1 | Scan or done cycle in progress |
| done | output | 1 | One-cycle result strobe |
| flipCount | output | $clog2(2*WIDTH+1) | Minimum flip count |

## Verification
The bench builds the block with the default WIDTH of 32. Every combination of 4-bit values for all three operands is driven, which covers each per-position case, the all-zero shortcut and every scan length from 0 to 4. Full-width vectors add the longest scan of 32 positions, the maximum count of 64, the three known results, and a start pulse issued partway through a long scan.

// File: rtl/orflip_pkg.sv
package orflip_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scanState_t;

  typedef struct packed {
    logic load;
    logic step;
  } ctlStrobes_t;

endpackage

// File: rtl/orflip_ctrl.sv
module orflip_ctrl
  import orflip_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        anyOne,
  input  logic        lastBit,
  output ctlStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  scanState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState    = state;
    strobes.load = 1'b0;
    strobes.step = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.load = 1'b1;
          nextState    = anyOne ? ST_SCAN : ST_DONE;
        end
      end
      ST_SCAN: begin
        strobes.step = 1'b1;
        if (lastBit) nextState = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/orflip_datapath.sv
module orflip_datapath
  import orflip_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobes_t                    strobes,
  input  logic [WIDTH-1:0]               opA,
  input  logic [WIDTH-1:0]               opB,
  input  logic [WIDTH-1:0]               opC,
  output logic                           anyOne,
  output logic                           lastBit,
  output logic [$clog2(2*WIDTH+1)-1:0]   flipCount
);

  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int CNT_W = $clog2(2*WIDTH+1);

  logic [WIDTH-1:0] aReg, bReg, cReg;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] msbIdx;
  logic [WIDTH-1:0] orAll;
  logic [CNT_W-1:0] countReg;
  logic [1:0]       bitCost;

  // highest set bit of the OR of the incoming operands
  assign orAll  = opA | opB | opC;
  assign anyOne = |orAll;

  always_comb begin
    msbIdx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (orAll[i]) msbIdx = IDX_W'(i);
    end
  end

  // cost of the position currently under the scan pointer
  always_comb begin
    if (!cReg[idx]) bitCost = {1'b0, aReg[idx]} + {1'b0, bReg[idx]};
    else            bitCost = {1'b0, ~(aReg[idx] | bReg[idx])};
  end

  assign lastBit = (idx == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg     <= '0;
      bReg     <= '0;
      cReg     <= '0;
      idx      <= '0;
      countReg <= '0;
    end else if (strobes.load) begin
      aReg     <= opA;
      bReg     <= opB;
      cReg     <= opC;
      idx      <= msbIdx;
      countReg <= '0;
    end else if (strobes.step) begin
      countReg <= countReg + CNT_W'(bitCost);
      if (!lastBit) idx <= idx - 1'b1;
    end
  end

  assign flipCount = countReg;

endmodule

// File: rtl/orflip_counter.sv
module orflip_counter
  import orflip_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [WIDTH-1:0]             opA,
  input  logic [WIDTH-1:0]             opB,
  input  logic [WIDTH-1:0]             opC,
  output logic                         busy,
  output logic                         done,
  output logic [$clog2(2*WIDTH+1)-1:0] flipCount
);

  ctlStrobes_t strobes;
  logic        anyOne;
  logic        lastBit;

  orflip_ctrl ctrlInst (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .anyOne  (anyOne),
    .lastBit (lastBit),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  orflip_datapath #(.WIDTH(WIDTH)) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .opC       (opC),
    .anyOne    (anyOne),
    .lastBit   (lastBit),
    .flipCount (flipCount)
  );

endmodule

// File: rtl/orflip_counter_chk.sv
module orflip_counter_chk #(
  parameter int WIDTH = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         start,
  input logic [WIDTH-1:0]             opA,
  input logic [WIDTH-1:0]             opB,
  input logic [WIDTH-1:0]             opC,
  input logic                         busy,
  input logic                         done,
  input logic [$clog2(2*WIDTH+1)-1:0] flipCount
);

  localparam int CNT_W = $clog2(2*WIDTH+1);
  localparam int LAT_W = $clog2(WIDTH+3);

  logic [LAT_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!busy && !done && flipCount == '0)); // R1

  AST_ZERO_SHORTCUT: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (opA | opB | opC) == '0) |=> (done && flipCount == '0)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(flipCount)); // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    flipCount <= CNT_W'(2*WIDTH)); // R8

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R9

  AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R9

  AST_SCAN_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun <= LAT_W'(WIDTH))); // R4

endmodule

bind orflip_counter orflip_counter_chk #(.WIDTH(WIDTH)) chkInst (.*);

// File: tb/orflip_counter_test.sv
module orflip_counter_test;

  localparam int WIDTH = 32;
  localparam int CNT_W = $clog2(2*WIDTH+1);

  logic             clk = 1'b0;
  logic             rstN;
  logic             start;
  logic [WIDTH-1:0] opA, opB, opC;
  logic             busy, done;
  logic [CNT_W-1:0] flipCount;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  orflip_counter #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .opA(opA), .opB(opB), .opC(opC),
    .busy(busy), .done(done), .flipCount(flipCount)
  );

  function automatic int refFlips(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, logic [WIDTH-1:0] c);
    int n = 0;
    for (int i = 0; i < WIDTH; i++) begin
      if (!c[i]) n += int'(a[i]) + int'(b[i]);
      else if (!a[i] && !b[i]) n += 1;
    end
    return n;
  endfunction

  function automatic int refLatency(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, logic [WIDTH-1:0] c);
    int m = -1;
    logic [WIDTH-1:0] o = a | b | c;
    for (int i = 0; i < WIDTH; i++) if (o[i]) m = i;
    return m + 1;
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // returns rising edges after the accepting edge until done is seen
  task automatic runOp(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input logic [WIDTH-1:0] c, output int lat, output int cnt);
    opA = a; opB = b; opC = c; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < WIDTH + 8) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    cnt = int'(flipCount);
  endtask

  task automatic fullCheck(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                           input logic [WIDTH-1:0] c, input string req);
    int lat, cnt, expC, expL;
    expC = refFlips(a, b, c);
    expL = refLatency(a, b, c);
    runOp(a, b, c, lat, cnt);
    check(cnt == expC, {req, " R2 R3 count"}, cnt, expC);
    check(lat == expL, {req, " R4 R5 latency"}, lat, expL);
    @(posedge clk);
    @(negedge clk);
    check(!done && !busy, {req, " R7 R9 done/busy low after pulse"}, int'({done, busy}), 0);
    check(int'(flipCount) == expC, {req, " R7 count held"}, int'(flipCount), expC);
  endtask

  initial begin
    int lat, cnt;
    rstN = 1'b0; start = 1'b0; opA = '0; opB = '0; opC = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && flipCount == '0, "R1 reset state", int'(flipCount), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && flipCount == '0, "R1 after release", int'({busy, done}), 0);

    // R10 known vectors
    runOp(32'd1, 32'd2, 32'd3, lat, cnt);
    check(cnt == 0, "R10 vector 1", cnt, 0);
    @(negedge clk);
    runOp(32'd51041, 32'd65280, 32'd716177407, lat, cnt);
    check(cnt == 14, "R10 vector 2", cnt, 14);
    @(negedge clk);
    runOp(32'd143165576, 32'd715827882, 32'd1, lat, cnt);
    check(cnt == 23, "R10 vector 3", cnt, 23);
    @(negedge clk);

    // R8 maximum count, longest scan
    fullCheck('1, '1, '0, "R8 max");
    check(int'(flipCount) == 64, "R8 value 64", int'(flipCount), 64);
    fullCheck('1, '0, '1, "R4 long zero-cost");
    fullCheck('0, '0, 32'h8000_0001, "R3 both zero sparse");

    // R5 all zero
    fullCheck('0, '0, '0, "R5 zero");

    // R6 start while busy ignored
    opA = 32'h8000_0000; opB = '0; opC = '0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy, "R9 busy after accept", int'(busy), 1);
    repeat (5) @(negedge clk);
    opA = '1; opB = '1; opC = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 6;
    while (!done && lat < WIDTH + 8) begin
      @(negedge clk);
      lat++;
    end
    check(int'(flipCount) == 1, "R6 count unchanged by late start", int'(flipCount), 1);
    check(lat == 32, "R6 latency unchanged by late start", lat, 32);
    @(negedge clk);
    check(!busy && int'(flipCount) == 1, "R6 idle after ignored start", int'(flipCount), 1);

    // exhaustive 4-bit sweep
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 16; c++) begin
          int expC, expL;
          expC = refFlips(WIDTH'(a), WIDTH'(b), WIDTH'(c));
          expL = refLatency(WIDTH'(a), WIDTH'(b), WIDTH'(c));
          runOp(WIDTH'(a), WIDTH'(b), WIDTH'(c), lat, cnt);
          check(cnt == expC, "R2 R3 sweep count", cnt, expC);
          check(lat == expL, "R4 R5 sweep latency", lat, expL);
          @(negedge clk);
        end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule